// File: doc/BRIEF.md
# Stream-Guarded Select Actor

This block is a token-consuming select for dataflow pipelines. It has three input streams (a one-bit steering stream, a "true" data stream and a "false" data stream) and one output stream. Every stream uses a valid/ready handshake. Each firing takes one steering token first. In the next step it takes one token from the data stream that the steering token names, and passes that token unchanged to a registered output.

A small state machine runs the block. Each state asserts ready only on the streams that state needs. A token waiting on the stream that was not picked stays with its producer and is delivered by a later firing that picks it. A data state waits while its stream is empty or while the output register is full and stalled. Because the steering step and the data step alternate, the block emits at most one token every two cycles.

Top module: `guarded_select`

## Requirements
- R1: After reset the machine is in the steering state with `outValid` low, `ctlReady` high and both data readies low.
- R2: In the steering state `ctlReady` is high and neither `trueReady` nor `falseReady` is asserted.
- R3: Accepting a steering token of value 1 moves the machine to the true state. In that state only `trueReady` can be high, and `ctlReady` is low.
- R4: Accepting a steering token of value 0 moves the machine to the false state. In that state only `falseReady` can be high, and `ctlReady` is low.
- R5: A data token accepted in a data state appears on `outData` with `outValid` high in the following cycle, with its value unchanged. The machine is then back in the steering state.
- R6: `trueReady` and `falseReady` are never high together, and the stream that was not picked is never consumed. Its pending token is the one delivered by the next firing that picks it.
- R7: A data state whose stream has no valid token holds its state and produces no output, and `ctlReady` stays low.
- R8: While `outValid` is high and `outReady` is low, `outData` and `outValid` hold their values and the data state's input ready is low. When `outReady` rises, the input ready rises in the same cycle.
- R9: With every stream continuously valid and the output always ready, the block emits exactly one token per two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlValid | input | 1 | Steering token present |
| ctlBit | input | 1 | Steering value: 1 picks true stream, 0 picks false stream |
| ctlReady | output | 1 | Steering token accepted this cycle when valid |
| trueValid | input | 1 | True-stream token present |
| trueData | input | DATA_W | True-stream token |
| trueReady | output | 1 | True-stream token accepted when valid |
| falseValid | input | 1 | False-stream token present |
| falseData | input | DATA_W | False-stream token |
| falseReady | output | 1 | False-stream token accepted when valid |
| outValid | output | 1 | Output register holds a token |
| outData | output | DATA_W | Output token |
| outReady | input | 1 | Downstream accepts the output token |

## Verification
The bench keeps a token waiting on the stream that is not picked while the other stream is taken. A design that wrongly consumes that token would deliver the wrong value when the token is later picked. It holds a data state empty for several cycles. A non-blocking design would then emit garbage or return to steering early. It stalls the output with a full register and checks that the input ready stays low. A design that gets this wrong would overwrite the held token. The bench also checks that ready returns in the cycle the stall lifts, which catches a design that adds a cycle of delay. Finally it counts outputs over a long saturated run, which catches a machine that skips the steering step or stalls in some cycles.

// File: rtl/guarded_select_pkg.sv
package guarded_select_pkg;
  typedef enum logic [1:0] {
    ST_STEER = 2'd0,
    ST_TRUE  = 2'd1,
    ST_FALSE = 2'd2
  } selState_t;

  typedef struct packed {
    logic loadTrue;
    logic loadFalse;
  } selStrobe_t;
endpackage

// File: rtl/guarded_select_ctrl.sv
module guarded_select_ctrl
  import guarded_select_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlValid,
  input  logic       ctlBit,
  input  logic       trueValid,
  input  logic       falseValid,
  input  logic       slotFree,
  output logic       ctlReady,
  output logic       trueReady,
  output logic       falseReady,
  output selStrobe_t strobe
);
  selState_t state, stateNext;

  always_comb begin
    ctlReady   = (state == ST_STEER);
    trueReady  = (state == ST_TRUE) && slotFree;
    falseReady = (state == ST_FALSE) && slotFree;
    strobe.loadTrue  = trueReady && trueValid;
    strobe.loadFalse = falseReady && falseValid;
    stateNext = state;
    unique case (state)
      ST_STEER: if (ctlValid) stateNext = ctlBit ? ST_TRUE : ST_FALSE;
      ST_TRUE:  if (strobe.loadTrue) stateNext = ST_STEER;
      ST_FALSE: if (strobe.loadFalse) stateNext = ST_STEER;
      default:  stateNext = ST_STEER;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_STEER;
    else       state <= stateNext;
  end
endmodule

// File: rtl/guarded_select_dp.sv
module guarded_select_dp
  import guarded_select_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  selStrobe_t        strobe,
  input  logic [DATA_W-1:0] trueData,
  input  logic [DATA_W-1:0] falseData,
  input  logic              outReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              slotFree
);
  logic loadAny;
  assign loadAny  = strobe.loadTrue | strobe.loadFalse;
  assign slotFree = !outValid || outReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else if (loadAny) begin
      outValid <= 1'b1;
      outData  <= strobe.loadTrue ? trueData : falseData;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/guarded_select.sv
module guarded_select
  import guarded_select_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlValid,
  input  logic              ctlBit,
  output logic              ctlReady,
  input  logic              trueValid,
  input  logic [DATA_W-1:0] trueData,
  output logic              trueReady,
  input  logic              falseValid,
  input  logic [DATA_W-1:0] falseData,
  output logic              falseReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  input  logic              outReady
);
  selStrobe_t strobe;
  logic       slotFree;

  guarded_select_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .ctlValid(ctlValid), .ctlBit(ctlBit),
    .trueValid(trueValid), .falseValid(falseValid),
    .slotFree(slotFree),
    .ctlReady(ctlReady), .trueReady(trueReady), .falseReady(falseReady),
    .strobe(strobe)
  );

  guarded_select_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe),
    .trueData(trueData), .falseData(falseData),
    .outReady(outReady),
    .outValid(outValid), .outData(outData),
    .slotFree(slotFree)
  );
endmodule

// File: rtl/guarded_select_checker.sv
module guarded_select_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctlReady,
  input logic              trueValid,
  input logic [DATA_W-1:0] trueData,
  input logic              trueReady,
  input logic              falseValid,
  input logic [DATA_W-1:0] falseData,
  input logic              falseReady,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              outReady
);
  assert_one_data_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(trueReady && falseReady));

  assert_steer_excludes_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctlReady |-> (!trueReady && !falseReady));

  assert_true_passthrough_R5: assert property (@(posedge clk) disable iff (!rstN)
    (trueValid && trueReady) |=> (outValid && outData == $past(trueData) && ctlReady));

  assert_false_passthrough_R5: assert property (@(posedge clk) disable iff (!rstN)
    (falseValid && falseReady) |=> (outValid && outData == $past(falseData) && ctlReady));

  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  assert_no_take_on_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> (!trueReady && !falseReady));
endmodule

bind guarded_select guarded_select_checker #(.DATA_W(DATA_W)) u_checker (
  .clk(clk), .rstN(rstN), .ctlReady(ctlReady),
  .trueValid(trueValid), .trueData(trueData), .trueReady(trueReady),
  .falseValid(falseValid), .falseData(falseData), .falseReady(falseReady),
  .outValid(outValid), .outData(outData), .outReady(outReady)
);

// File: tb/guarded_select_test.sv
`timescale 1ns/1ps
module guarded_select_test;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctlValid = 1'b0, ctlBit = 1'b0;
  logic trueValid = 1'b0, falseValid = 1'b0, outReady = 1'b1;
  logic [DATA_W-1:0] trueData = '0, falseData = '0;
  logic ctlReady, trueReady, falseReady, outValid;
  logic [DATA_W-1:0] outData;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  guarded_select #(.DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN),
    .ctlValid(ctlValid), .ctlBit(ctlBit), .ctlReady(ctlReady),
    .trueValid(trueValid), .trueData(trueData), .trueReady(trueReady),
    .falseValid(falseValid), .falseData(falseData), .falseReady(falseReady),
    .outValid(outValid), .outData(outData), .outReady(outReady)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // advance one edge, land on the falling edge for driving
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) step();
    rstN = 1'b1;
    #1;
    chk("R1 outValid", outValid, 0);
    chk("R1 ctlReady", ctlReady, 1);
    chk("R1 trueReady", trueReady, 0);
    chk("R1 falseReady", falseReady, 0);
  endtask

  task automatic testTruePick();
    ctlValid = 1; ctlBit = 1; outReady = 1;
    falseValid = 1; falseData = 8'hAA; trueValid = 0;
    #1;
    chk("R2 ctlReady steer", ctlReady, 1);
    chk("R2 falseReady steer", falseReady, 0);
    step();
    ctlValid = 0;
    #1;
    chk("R3 trueReady", trueReady, 1);
    chk("R6 falseReady in true state", falseReady, 0);
    chk("R3 ctlReady low", ctlReady, 0);
    step(); step();
    #1;
    chk("R7 blocked no output", outValid, 0);
    chk("R7 blocked ctlReady", ctlReady, 0);
    chk("R7 still waits true", trueReady, 1);
    trueValid = 1; trueData = 8'h5C;
    step();
    trueValid = 0;
    #1;
    chk("R5 outValid", outValid, 1);
    chk("R5 outData", outData, 8'h5C);
    chk("R5 back to steer", ctlReady, 1);
    step();
  endtask

  task automatic testFalsePick();
    ctlValid = 1; ctlBit = 0;
    step();
    ctlValid = 0;
    #1;
    chk("R4 falseReady", falseReady, 1);
    chk("R4 trueReady low", trueReady, 0);
    chk("R4 ctlReady low", ctlReady, 0);
    step();
    falseValid = 0;
    #1;
    chk("R6 held token delivered", outData, 8'hAA);
    chk("R6 outValid", outValid, 1);
    step();
  endtask

  task automatic testBackPressure();
    outReady = 0;
    ctlValid = 1; ctlBit = 1; trueValid = 1; trueData = 8'h33;
    step();
    ctlValid = 0;
    #1;
    chk("R8 empty slot ready", trueReady, 1);
    step();
    trueData = 8'h44; ctlValid = 1; ctlBit = 1;
    #1;
    chk("R8 first out", outData, 8'h33);
    step();
    ctlValid = 0;
    #1;
    chk("R8 stalled trueReady", trueReady, 0);
    step();
    #1;
    chk("R8 held valid", outValid, 1);
    chk("R8 held data", outData, 8'h33);
    chk("R8 still stalled", trueReady, 0);
    outReady = 1;
    #1;
    chk("R8 same-cycle ready", trueReady, 1);
    step();
    trueValid = 0;
    #1;
    chk("R8 next token", outData, 8'h44);
    chk("R8 next valid", outValid, 1);
    step();
    #1;
    chk("R8 drained", outValid, 0);
  endtask

  task automatic testThroughput();
    int outs = 0;
    int falseSeen = 0;
    outReady = 1;
    ctlValid = 1; ctlBit = 1;
    trueValid = 1; trueData = 8'h77;
    falseValid = 1; falseData = 8'h99;
    for (int i = 0; i < 20; i++) begin
      if (falseReady) falseSeen++;
      step();
      #1;
      if (outValid) outs++;
    end
    chk("R9 outputs in 20 cycles", outs, 10);
    chk("R6 false never ready", falseSeen, 0);
    ctlValid = 0; trueValid = 0; falseValid = 0;
    step(); step();
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testTruePick();
    testFalsePick();
    testBackPressure();
    testThroughput();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule